// File: doc/BRIEF.md
# Lane Stop-State Timeout Detector

This block sits beside a serial camera D-PHY receiver and decides when the receive lanes have settled into their low-power stop state. Software programs a count and two prescaler enables, then arms a receive-mode request bit. While that bit is armed, the block counts functional-clock cycles for as long as every enabled lane reports stop state. The count restarts whenever an enabled lane leaves stop state. When the count reaches the programmed timeout, the block clears the request bit by itself and raises a stop-detected status.

The timeout in functional-clock cycles is the programmed count times a multiplier. The multiplier is 16 when the x16 enable is set and 4 when the x4 enable is set, so with both set it is 64. With the count chosen as ceil(fclk_Hz / 640000) and both enables set, the timeout is at least 100 us. Software polls the request bit and gives up with an error if it is still set after a long bound of its own, for example 750 ms.

Top module: `lane_idle_watch`

## Requirements
- R1: After reset, `rx_force` and `stop_seen` are both 0.
- R2: A cycle with `cfg_wr`=1 loads `cfg_count`, `cfg_x16` and `cfg_x4`, sets `rx_force` to the value of `cfg_force` from the next cycle on, clears `stop_seen`, and restarts the timeout count. Writing `cfg_force`=0 while armed drops `rx_force` without setting `stop_seen`.
- R3: If every enabled lane holds stop state throughout, `rx_force` stays 1 for exactly T cycles after the arming write. T = C × (`cfg_x16` ? 16 : 1) × (`cfg_x4` ? 4 : 1), which gives multipliers of 1, 4, 16 or 64.
- R4: A programmed count of 0 is treated as C = 1. Otherwise C is the 13-bit `cfg_count` value.
- R5: A lane whose `lane_en` bit is 0 is ignored. Its `lane_stop` value does not change T, and with an all-zero mask the timeout runs unconditionally.
- R6: If an enabled lane shows `lane_stop`=0 in any cycle while armed, the count returns to zero. With d good cycles before a single one-cycle drop (d < T), `rx_force` stays high for d + 1 + T cycles.
- R7: `stop_seen` becomes 1 on the same clock edge where the timeout clears `rx_force`, and it stays 1 until the next write.
- R8: While `rx_force` is 0, lane activity changes neither output, and the count is held at zero. A later arming write therefore sees the full T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_count | input | 13 | Stop-state count value |
| cfg_x16 | input | 1 | Prescaler enable, multiply by 16 |
| cfg_x4 | input | 1 | Prescaler enable, multiply by 4 |
| cfg_force | input | 1 | Receive-mode request value written |
| lane_en | input | 5 | Mask of enabled lanes |
| lane_stop | input | 5 | Per-lane stop-state indication |
| rx_force | output | 1 | Receive-mode request; cleared by hardware on timeout |
| stop_seen | output | 1 | Stop state reached on all enabled lanes |

## Verification
A wrong elapsed count or a wrong target shows up only as a wrong length of the `rx_force` pulse. The bench therefore measures that pulse, in cycles, against the product it computes itself for every small count and every prescaler pairing. A restart that fails to clear the count shortens the pulse by exactly the number of good cycles before the drop, and so shows up within one timeout. A count left stale while disarmed shortens the next armed pulse, which the idle-activity sequence followed by a re-arm exposes.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
  localparam int MULT_X16 = 16;
  localparam int MULT_X4  = 4;

  // Timeout in functional-clock cycles; a zero count behaves as one.
  function automatic logic [31:0] lsw_target(input logic [15:0] count,
                                             input logic x16, input logic x4);
    logic [31:0] c;
    c = (count == 16'd0) ? 32'd1 : {16'd0, count};
    if (x16) c = c * MULT_X16;
    if (x4)  c = c * MULT_X4;
    return c;
  endfunction
endpackage

// File: rtl/lsw_lane_qual.sv
module lsw_lane_qual #(
  parameter int LANES = 5
) (
  input  logic [LANES-1:0] lane_en,
  input  logic [LANES-1:0] lane_stop,
  output logic             all_stop
);
  logic [LANES-1:0] lane_ok;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_ok[i] = lane_stop[i] | ~lane_en[i];
  end

  assign all_stop = &lane_ok;
endmodule

// File: rtl/lsw_cfg_regs.sv
module lsw_cfg_regs #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_count,
  input  logic             wr_x16,
  input  logic             wr_x4,
  input  logic             wr_force,
  input  logic             expire,
  output logic [CNT_W-1:0] count_q,
  output logic             x16_q,
  output logic             x4_q,
  output logic             force_q,
  output logic             seen_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      x16_q   <= 1'b0;
      x4_q    <= 1'b0;
      force_q <= 1'b0;
      seen_q  <= 1'b0;
    end else if (wr) begin
      count_q <= wr_count;
      x16_q   <= wr_x16;
      x4_q    <= wr_x4;
      force_q <= wr_force;
      seen_q  <= 1'b0;
    end else if (expire) begin
      force_q <= 1'b0;
      seen_q  <= 1'b1;
    end
  end

  AST_CLEAR_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_q) |-> $past(wr) || $past(expire)); // R2
  AST_SEEN_WITH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !wr) |=> (seen_q && !force_q)); // R7
  AST_SEEN_ONLY_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seen_q) |-> $past(expire)); // R7
endmodule

// File: rtl/lsw_timer.sv
module lsw_timer #(
  parameter int CNT_W = 13,
  localparam int TW = CNT_W + 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             armed,
  input  logic             all_stop,
  input  logic [CNT_W-1:0] count_q,
  input  logic             x16_q,
  input  logic             x4_q,
  output logic             expire
);
  import lsw_pkg::*;

  logic [TW-1:0] target;
  logic [TW-1:0] elapsed;
  logic          run;

  assign target = TW'(lsw_target(16'(count_q), x16_q, x4_q));
  assign run    = armed && all_stop;
  assign expire = run && (elapsed == target - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 elapsed <= '0;
    else if (wr || !run)        elapsed <= '0;
    else if (expire)            elapsed <= '0;
    else                        elapsed <= elapsed + TW'(1);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    elapsed < target); // R3
  AST_RESTART_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !all_stop) |=> (elapsed == '0)); // R6
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (elapsed == '0)); // R8
  AST_TARGET_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    target != '0); // R4
endmodule

// File: rtl/lane_idle_watch.sv
module lane_idle_watch #(
  parameter int LANES = 5,
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             cfg_x16,
  input  logic             cfg_x4,
  input  logic             cfg_force,
  input  logic [LANES-1:0] lane_en,
  input  logic [LANES-1:0] lane_stop,
  output logic             rx_force,
  output logic             stop_seen
);
  logic             all_stop;
  logic             expire;
  logic [CNT_W-1:0] count_q;
  logic             x16_q;
  logic             x4_q;

  lsw_lane_qual #(.LANES(LANES)) u_qual (
    .lane_en(lane_en), .lane_stop(lane_stop), .all_stop(all_stop));

  lsw_cfg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wr_count(cfg_count),
    .wr_x16(cfg_x16), .wr_x4(cfg_x4), .wr_force(cfg_force),
    .expire(expire), .count_q(count_q), .x16_q(x16_q), .x4_q(x4_q),
    .force_q(rx_force), .seen_q(stop_seen));

  lsw_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .armed(rx_force),
    .all_stop(all_stop), .count_q(count_q), .x16_q(x16_q), .x4_q(x4_q),
    .expire(expire));

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_force && !cfg_wr) |=> (!rx_force && $stable(stop_seen))); // R8
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_force && stop_seen)); // R7
endmodule

// File: tb/sim_lane_idle_watch.sv
module sim_lane_idle_watch;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 5;
  localparam int CNT_W = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [CNT_W-1:0] cfg_count = '0;
  logic cfg_x16 = 1'b0, cfg_x4 = 1'b0, cfg_force = 1'b0;
  logic [LANES-1:0] lane_en = '1;
  logic [LANES-1:0] lane_stop = '1;
  logic rx_force, stop_seen;

  int vectors = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_idle_watch #(.LANES(LANES), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_count(cfg_count),
    .cfg_x16(cfg_x16), .cfg_x4(cfg_x4), .cfg_force(cfg_force),
    .lane_en(lane_en), .lane_stop(lane_stop),
    .rx_force(rx_force), .stop_seen(stop_seen));

  function automatic int exp_t(int c, bit a16, bit a4);
    int m;
    m = (a16 ? 16 : 1) * (a4 ? 4 : 1);
    return (c == 0 ? 1 : c) * m;
  endfunction

  task automatic check(string req, int act, int expv);
    vectors++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Write at one edge; returns at the following negedge.
  task automatic do_write(int c, bit a16, bit a4, bit f);
    cfg_wr = 1'b1; cfg_count = CNT_W'(c); cfg_x16 = a16; cfg_x4 = a4; cfg_force = f;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Count armed cycles; enabled lanes drop for one cycle at index drop_at.
  task automatic measure(int drop_at, logic [LANES-1:0] good, output int n);
    n = 0;
    while (rx_force && n < 3000) begin
      lane_stop = (n == drop_at) ? ~lane_en : good;
      n++;
      @(negedge clk);
    end
    lane_stop = good;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 rx_force", rx_force, 0);
    check("R1 stop_seen", stop_seen, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3, R4, R7: sweep small counts over every prescaler pairing
    for (int c = 0; c <= 5; c++) begin
      for (int p = 0; p < 4; p++) begin
        do_write(c, p[1], p[0], 1'b1);
        check("R2 armed", rx_force, 1);
        check("R2 seen cleared", stop_seen, 0);
        measure(-1, '1, n);
        check((c == 0) ? "R4 zero count" : "R3 timeout", n, exp_t(c, p[1], p[0]));
        check("R7 seen", stop_seen, 1);
      end
    end

    // R5: disabled lanes active, only lanes 0,1 enabled
    lane_en = 5'b00011;
    do_write(7, 1'b0, 1'b1, 1'b1);
    measure(-1, 5'b00011, n);
    check("R5 masked lanes", n, 28);
    lane_en = 5'b00000;
    lane_stop = '0;
    do_write(3, 1'b1, 1'b0, 1'b1);
    measure(-1, 5'b00000, n);
    check("R5 empty mask", n, 48);
    lane_en = '1; lane_stop = '1;

    // R6: single-cycle drop restarts count
    for (int d = 0; d < 12; d += 3) begin
      do_write(3, 1'b0, 1'b1, 1'b1);
      measure(d, '1, n);
      check("R6 restart", n, d + 1 + 12);
    end

    // R2: abort write clears without status
    do_write(50, 1'b1, 1'b1, 1'b1);
    repeat (10) @(negedge clk);
    do_write(50, 1'b1, 1'b1, 1'b0);
    check("R2 abort force", rx_force, 0);
    check("R2 abort seen", stop_seen, 0);

    // R8: lane activity while disarmed, then full timeout on re-arm
    for (int i = 0; i < 20; i++) begin
      lane_stop = LANES'(i * 7);
      @(negedge clk);
      check("R8 idle force", rx_force, 0);
      check("R8 idle seen", stop_seen, 0);
    end
    lane_stop = '1;
    do_write(2, 1'b1, 1'b0, 1'b1);
    measure(-1, '1, n);
    check("R8 full timeout", n, 32);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule